// File: doc/BRIEF.md
# Peripheral Chip Select Decoder

This block turns a bus address into a small set of active-low peripheral select lines. Software places the peripheral block at a base address aligned to 1 KB and chooses whether that block sits in memory space or in I/O space. Each select line then owns one 256-byte window, and the windows lie back to back above the base: select 0 takes the lowest window, select 1 the next, and so on.

Each clock the decoder samples the bus page (the address with its byte-within-window bits stripped), the space type of the cycle and a cycle-active strobe. It drives the matching select low on the following clock edge. When the bus is granted to another master, or while reset is asserted, every select is held high. Until software has written the base register once after reset, no select asserts at all.

Top module: `pcs_decoder`

## Requirements
- R1: A select output covers exactly 256 bytes. A bus page (address divided by 256) inside the programmed 1 KB block asserts one select. A page just below or just above the block asserts none.
- R2: The select index equals bus page bits [1:0], which are address bits [9:8]. Pages base+0, +1, +2 and +3 drive pcs_n[0], pcs_n[1], pcs_n[2] and pcs_n[3] low.
- R3: A write with cfg_we high loads cfg_base_blk, which holds address bits [19:10] of the base, and cfg_mem_space. The block then decodes the pages whose upper 10 bits equal cfg_base_blk.
- R4: A select asserts only when bus_is_mem equals the configured space. A value of 1 means memory space and 0 means I/O space.
- R5: While rst is high at a clock edge, every pcs_n bit is 1 after that edge.
- R6: While hold_granted is high at a clock edge, every pcs_n bit is 1 after that edge, whatever the address.
- R7: After reset, and before the first write to the base register, no select asserts.
- R8: A select asserts only for a clock edge at which bus_active is 1.
- R9: The outputs are registered. pcs_n after edge k reflects the inputs sampled at edge k, and at most one bit is low at any time.
- R10: A bus cycle sampled at the same edge as a configuration write is decoded with the configuration that held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the base register |
| cfg_base_blk | input | 10 | Base address bits [19:10] |
| cfg_mem_space | input | 1 | 1 places the block in memory space, 0 in I/O space |
| bus_page | input | 12 | Bus address bits [19:8] |
| bus_is_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| bus_active | input | 1 | A bus cycle is in progress |
| hold_granted | input | 1 | The bus is granted to another master |
| pcs_n | output | 4 | Active-low peripheral selects |

## Verification
The assertions assume that every input is synchronous to clk and holds steady across each rising edge. They also assume that the select count fits inside one 1 KB block, so a page index never names a select that does not exist. The bench keeps to these assumptions by changing every input on the falling edge only. It draws its random pages from inside and around the programmed block, and from the page counter's full range. Reset and hold are raised at arbitrary cycles, including the cycle of a configuration write.

// File: rtl/pcsd_pkg.sv
package pcsd_pkg;

    localparam int ADDR_W     = 20;
    localparam int WIN_BITS   = 8;
    localparam int ALIGN_BITS = 10;
    localparam int NUM_SEL    = 4;
    localparam int PAGE_W     = ADDR_W - WIN_BITS;
    localparam int BASE_W     = ADDR_W - ALIGN_BITS;
    localparam int IDX_W      = ALIGN_BITS - WIN_BITS;
    localparam int MAX_WIN    = 1 << IDX_W;

    typedef enum logic {
        SPACE_IO  = 1'b0,
        SPACE_MEM = 1'b1
    } space_e;

    typedef struct packed {
        logic              valid;
        space_e            space;
        logic [BASE_W-1:0] base;
    } cfg_t;

    typedef struct packed {
        logic              active;
        space_e            space;
        logic [BASE_W-1:0] blk;
        logic [IDX_W-1:0]  idx;
    } cycle_t;

    function automatic space_e to_space(input logic is_mem);
        return is_mem ? SPACE_MEM : SPACE_IO;
    endfunction

    function automatic cycle_t split_cycle(input logic [PAGE_W-1:0] page,
                                           input logic is_mem,
                                           input logic active);
        cycle_t c;
        c.active = active;
        c.space  = to_space(is_mem);
        c.blk    = page[PAGE_W-1:IDX_W];
        c.idx    = page[IDX_W-1:0];
        return c;
    endfunction

    function automatic logic block_hit(input cfg_t cfg, input cycle_t cyc);
        return cfg.valid && cyc.active && (cyc.space == cfg.space)
               && (cyc.blk == cfg.base);
    endfunction

endpackage

// File: rtl/pcsd_cfg_reg.sv
module pcsd_cfg_reg
    import pcsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BASE_W-1:0] base_in,
    input  logic              mem_in,
    output cfg_t              cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.valid <= 1'b0;
            cfg_q.space <= SPACE_IO;
            cfg_q.base  <= '0;
        end else if (we) begin
            cfg_q.valid <= 1'b1;
            cfg_q.space <= to_space(mem_in);
            cfg_q.base  <= base_in;
        end
    end

    assert_write_loads_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg_q.valid && cfg_q.base == $past(base_in)
                && cfg_q.space == to_space($past(mem_in))));

    assert_keep_without_write_R3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg_q));

endmodule

// File: rtl/pcsd_window_match.sv
module pcsd_window_match
    import pcsd_pkg::*;
#(
    parameter int N_SEL = NUM_SEL
)(
    input  cfg_t             cfg,
    input  cycle_t           cyc,
    output logic [N_SEL-1:0] sel
);

    logic hit;

    always_comb hit = block_hit(cfg, cyc);

    for (genvar i = 0; i < N_SEL; i++) begin : g_win
        if (i < MAX_WIN) begin : g_fit
            always_comb sel[i] = hit && (cyc.idx == IDX_W'(i));
        end else begin : g_none
            always_comb sel[i] = 1'b0;
        end
    end

endmodule

// File: rtl/pcsd_out_stage.sv
module pcsd_out_stage
    import pcsd_pkg::*;
#(
    parameter int N_SEL = NUM_SEL
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [N_SEL-1:0] sel,
    output logic [N_SEL-1:0] pcs_n
);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            pcs_n <= '1;
        end else begin
            pcs_n <= ~sel;
        end
    end

    assert_reset_high_R5: assert property (@(posedge clk)
        rst |=> (&pcs_n));

    assert_hold_high_R6: assert property (@(posedge clk) disable iff (rst)
        hold |=> (&pcs_n));

    assert_single_select_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~pcs_n));

endmodule

// File: rtl/pcs_decoder.sv
module pcs_decoder
    import pcsd_pkg::*;
#(
    parameter int N_SEL = NUM_SEL
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [BASE_W-1:0] cfg_base_blk,
    input  logic              cfg_mem_space,
    input  logic [PAGE_W-1:0] bus_page,
    input  logic              bus_is_mem,
    input  logic              bus_active,
    input  logic              hold_granted,
    output logic [N_SEL-1:0]  pcs_n
);

    cfg_t             cfg_q;
    cycle_t           cyc;
    logic [N_SEL-1:0] sel;

    always_comb cyc = split_cycle(bus_page, bus_is_mem, bus_active);

    pcsd_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .base_in (cfg_base_blk),
        .mem_in  (cfg_mem_space),
        .cfg_q   (cfg_q)
    );

    pcsd_window_match #(.N_SEL(N_SEL)) u_match (
        .cfg (cfg_q),
        .cyc (cyc),
        .sel (sel)
    );

    pcsd_out_stage #(.N_SEL(N_SEL)) u_out (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold_granted),
        .sel   (sel),
        .pcs_n (pcs_n)
    );

    assert_space_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (to_space(bus_is_mem) != cfg_q.space) |=> (&pcs_n));

    assert_unprogrammed_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.valid |=> (&pcs_n));

    assert_active_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_active |=> (&pcs_n));

    assert_outside_block_R1: assert property (@(posedge clk) disable iff (rst)
        (cyc.blk != cfg_q.base) |=> (&pcs_n));

    assert_index_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.valid && bus_active && !hold_granted
         && to_space(bus_is_mem) == cfg_q.space
         && cyc.blk == cfg_q.base && int'(cyc.idx) < N_SEL)
        |=> !pcs_n[$past(cyc.idx)]);

endmodule

// File: tb/pcs_decoder_tb_top.sv
module pcs_decoder_tb_top;
    import pcsd_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_we;
    logic [BASE_W-1:0] cfg_base_blk;
    logic              cfg_mem_space;
    logic [PAGE_W-1:0] bus_page;
    logic              bus_is_mem;
    logic              bus_active;
    logic              hold_granted;
    logic [NUM_SEL-1:0] pcs_n;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R5";
    bit    started  = 1'b0;

    // reference model state
    bit                 m_valid = 1'b0;
    bit                 m_mem   = 1'b0;
    int                 m_base  = 0;
    logic [NUM_SEL-1:0] exp_pcs = '1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcs_decoder dut_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (cfg_we),
        .cfg_base_blk  (cfg_base_blk),
        .cfg_mem_space (cfg_mem_space),
        .bus_page      (bus_page),
        .bus_is_mem    (bus_is_mem),
        .bus_active    (bus_active),
        .hold_granted  (hold_granted),
        .pcs_n         (pcs_n)
    );

    always @(posedge clk) begin
        int pg;
        pg = int'(bus_page);
        exp_pcs = '1;
        if (!rst && !hold_granted && m_valid && bus_active
            && (bus_is_mem == m_mem) && ((pg / MAX_WIN) == m_base)
            && ((pg % MAX_WIN) < NUM_SEL))
            exp_pcs[pg % MAX_WIN] = 1'b0;
        if (rst) begin
            m_valid = 1'b0;
            m_mem   = 1'b0;
            m_base  = 0;
        end else if (cfg_we) begin
            m_valid = 1'b1;
            m_mem   = cfg_mem_space;
            m_base  = int'(cfg_base_blk);
        end
        started = 1'b1;
    end

    always @(negedge clk) begin
        if (started) begin
            n_checks++;
            if (pcs_n !== exp_pcs) begin
                n_fail++;
                $display("FAIL %s cycle compare: actual=%b expected=%b", cur_req, pcs_n, exp_pcs);
            end
        end
    end

    task automatic expect_pcs(input logic [NUM_SEL-1:0] want, input string req);
        n_checks++;
        if (pcs_n !== want) begin
            n_fail++;
            $display("FAIL %s directed: actual=%b expected=%b", req, pcs_n, want);
        end
    endtask

    task automatic drive(input int page, input bit mem, input bit act, input bit hold);
        bus_page     = PAGE_W'(page);
        bus_is_mem   = mem;
        bus_active   = act;
        hold_granted = hold;
        @(negedge clk);
    endtask

    task automatic write_base(input int blk, input bit mem);
        cfg_we        = 1'b1;
        cfg_base_blk  = BASE_W'(blk);
        cfg_mem_space = mem;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_base_blk = '0; cfg_mem_space = 1'b0;
        bus_page = '0; bus_is_mem = 1'b0; bus_active = 1'b0; hold_granted = 1'b0;
        repeat (3) @(negedge clk);
        expect_pcs('1, "R5");
        rst = 1'b0;

        // R7: nothing before the first base write, even at page 0..7
        cur_req = "R7";
        for (int p = 0; p < 8; p++) begin
            drive(p, 1'b1, 1'b1, 1'b0);
            expect_pcs('1, "R7");
            drive(p, 1'b0, 1'b1, 1'b0);
        end

        // R3: base block 0x049 in memory space -> pages 0x124..0x127
        cur_req = "R3";
        write_base('h049, 1'b1);

        // R1 / R2: sweep across and past the block
        cur_req = "R1";
        for (int p = 'h120; p < 'h12c; p++) drive(p, 1'b1, 1'b1, 1'b0);
        cur_req = "R2";
        drive('h124, 1'b1, 1'b1, 1'b0); expect_pcs(4'b1110, "R2");
        drive('h125, 1'b1, 1'b1, 1'b0); expect_pcs(4'b1101, "R2");
        drive('h126, 1'b1, 1'b1, 1'b0); expect_pcs(4'b1011, "R2");
        drive('h127, 1'b1, 1'b1, 1'b0); expect_pcs(4'b0111, "R2");
        cur_req = "R1";
        drive('h123, 1'b1, 1'b1, 1'b0); expect_pcs('1, "R1");
        drive('h128, 1'b1, 1'b1, 1'b0); expect_pcs('1, "R1");

        // R4: space mismatch
        cur_req = "R4";
        drive('h125, 1'b0, 1'b1, 1'b0); expect_pcs('1, "R4");
        drive('h125, 1'b1, 1'b1, 1'b0); expect_pcs(4'b1101, "R4");

        // R8: inactive strobe
        cur_req = "R8";
        drive('h125, 1'b1, 1'b0, 1'b0); expect_pcs('1, "R8");

        // R6: hold forces high, release restores
        cur_req = "R6";
        drive('h126, 1'b1, 1'b1, 1'b1); expect_pcs('1, "R6");
        drive('h126, 1'b1, 1'b1, 1'b0); expect_pcs(4'b1011, "R6");

        // R9: one-edge latency, output follows new page
        cur_req = "R9";
        drive('h127, 1'b1, 1'b1, 1'b0); expect_pcs(4'b0111, "R9");
        drive('h000, 1'b1, 1'b1, 1'b0); expect_pcs('1, "R9");

        // R10: write in the same edge as a bus cycle uses the old base
        cur_req = "R10";
        bus_page = 12'h124; bus_is_mem = 1'b1; bus_active = 1'b1;
        write_base('h001, 1'b0);
        expect_pcs(4'b1110, "R10");
        cur_req = "R3";
        drive('h124, 1'b1, 1'b1, 1'b0); expect_pcs('1, "R3");
        drive('h005, 1'b0, 1'b1, 1'b0); expect_pcs(4'b1101, "R3");

        // R5 mid-run, then R7 again after reset
        cur_req = "R5";
        rst = 1'b1;
        drive('h005, 1'b0, 1'b1, 1'b0); expect_pcs('1, "R5");
        rst = 1'b0;
        cur_req = "R7";
        drive('h005, 1'b0, 1'b1, 1'b0); expect_pcs('1, "R7");

        // mixed random traffic
        cur_req = "R1";
        for (int k = 0; k < 3000; k++) begin
            int blk;
            int pg;
            blk = int'($urandom_range(0, (1 << BASE_W) - 1));
            if ((k % 200) == 0) write_base(blk, 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) == 0) pg = int'($urandom_range(0, (1 << PAGE_W) - 1));
            else pg = m_base * MAX_WIN + int'($urandom_range(0, MAX_WIN + 1)) - 1;
            if (pg < 0) pg = 0;
            rst = ($urandom_range(0, 499) == 0);
            cfg_we = ($urandom_range(0, 63) == 0);
            cfg_base_blk = BASE_W'(blk);
            cfg_mem_space = 1'($urandom_range(0, 1));
            drive(pg, 1'($urandom_range(0, 1)), ($urandom_range(0, 4) != 0),
                  ($urandom_range(0, 9) == 0));
            cfg_we = 1'b0;
            rst = 1'b0;
        end

        drive(0, 1'b0, 1'b0, 1'b0);
        finish_run();
    end

endmodule